// File: doc/BRIEF.md
# Block-Counted Card Data Transfer Sequencer

This block moves payload bytes between a byte-wide card data stream and an external FIFO whose entries are 16 bits wide. It runs a transfer made of a programmed number of blocks, each a programmed number of bytes. When receiving, it packs two card bytes into each FIFO entry, low half first. When transmitting, it unpacks each head entry into two card bytes, low half first. A block of odd length leaves its last entry half used. Byte handshakes in both directions use valid/ready, and at most one byte moves per clock.

Software programs a byte-length register and a block-count register. Each stores its 11-bit field plus one, so the range is 1 to 2048. Two live counters track progress and are what software reads back. A data-transfer command starts the sequencer: it flushes the FIFO and latches the direction. The sequencer pauses while the FIFO is too full to receive into, or empty when transmitting. After the final byte of the final block, the counters reload by themselves and the transfer ends with a completion pulse.

Top module: `xfer_seq`

## Requirements
- R1: After reset the sequencer is idle: `xfer_active`=0, `live_bytes`=0, `live_blocks`=0, and `rx_ready` and `tx_valid` are low.
- R2: A write with `reg_wr_sel`=0 stores bits [10:0] of `reg_wr_data` plus one as the block byte length, and also loads it into `live_bytes`. Bits [15:11] are ignored, so field 0x7FF gives 2048.
- R3: A write with `reg_wr_sel`=1 stores bits [10:0] plus one as the block count and loads it into `live_blocks`. The same write reloads `live_bytes` from the stored byte length.
- R4: A command with `cmd_type`=3 (data transfer) pulses `fifo_flush` in its own cycle, sets `xfer_active` and latches `cmd_dir` (1 = receive from card) into `xfer_dir`. Any other `cmd_type` (0, 1 or 2) clears `xfer_active` and does not flush.
- R5: On receive, the first byte of a pair goes into bits [7:0] of a FIFO entry and the second into bits [15:8]. The entry is pushed in the cycle the second byte is accepted.
- R6: On receive, when the byte accepted into the low half is the last byte of its block, the entry is pushed at once with bits [15:8] = 0.
- R7: On receive, at the start of an entry, `rx_ready` stays low while `fifo_level` is greater than `af_level`.
- R8: On transmit, bits [7:0] of the head entry are sent first and then bits [15:8], and the entry is popped with the second byte. When the low byte is the last byte of its block, the entry is popped after that byte alone.
- R9: On transmit, `tx_valid` is low while `fifo_level` is 0.
- R10: Each moved byte decrements `live_bytes`. When a block's last byte moves, `live_bytes` reloads the byte length and `live_blocks` decrements.
- R11: When the last byte of the last block moves, `live_blocks` reloads the block count, `xfer_active` falls, and `xfer_done` is high for exactly the next cycle.
- R12: At most one byte moves per clock. `rx_ready` and `tx_valid` are never high together, and neither is high while no transfer is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 = byte length register, 1 = block count register |
| reg_wr_data | input | 16 | Write data; bits [10:0] used |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_type | input | 2 | Command kind; 3 = data transfer |
| cmd_dir | input | 1 | Direction of a data command, 1 = receive |
| af_level | input | 5 | Receive pause threshold on the FIFO fill level |
| fifo_level | input | 6 | Current FIFO fill count (0..32) |
| fifo_head | input | 16 | FIFO head entry |
| fifo_flush | output | 1 | Clear the FIFO pointers |
| fifo_push | output | 1 | Push `fifo_push_data` |
| fifo_push_data | output | 16 | Packed entry to push |
| fifo_pop | output | 1 | Pop the head entry |
| rx_valid | input | 1 | Card byte available |
| rx_data | input | 8 | Card byte |
| rx_ready | output | 1 | Sequencer takes the card byte |
| tx_valid | output | 1 | Byte for the card available |
| tx_data | output | 8 | Byte for the card |
| tx_ready | input | 1 | Card takes the byte |
| xfer_active | output | 1 | Transfer in progress |
| xfer_dir | output | 1 | Latched direction, 1 = receive |
| xfer_done | output | 1 | One-cycle completion pulse |
| live_bytes | output | 12 | Live byte counter |
| live_blocks | output | 12 | Live block counter |

## Verification
The bench runs odd block lengths, including a length of one. A design that dropped the half-used entry, or put the lone byte in the high half, would show a missing or wrong pushed word. It also pops a short transmit block. There, a pop held back for a high byte that never comes would shift every later byte. It runs the receive side against a low threshold, and lets the FIFO run dry in the middle of a transmit, so a sequencer that ignores either pause shows up as an overflow or as bytes sent with nothing behind them. Counter reload is checked at block and transfer boundaries, together with the register ignoring its upper bits and the rule that a non-transfer command stops without flushing. A wrong reload or a stray flush would leave the readback values or the completion pulse off.

// File: rtl/xfer_seq_pkg.sv
// Package: shared constants and command kinds for the transfer sequencer.
// Assumes the command type field is two bits wide and code 3 means data transfer.
package xfer_seq_pkg;

    typedef enum logic [1:0] {
        CMD_KIND_BCAST     = 2'd0,
        CMD_KIND_BCAST_RSP = 2'd1,
        CMD_KIND_ADDRESSED = 2'd2,
        CMD_KIND_DATA      = 2'd3
    } cmd_kind_e;

    localparam int unsigned BYTE_BITS = 8;

endpackage

// File: rtl/xfer_blk_counters.sv
// Module: holds the programmed byte length and block count and their live
// counters. A register write takes priority over a byte step in the same cycle.
// Assumes step is asserted at most once per clock.
module xfer_blk_counters #(
    parameter int unsigned FIELD_W = 11,
    parameter int unsigned REG_W   = 16,
    localparam int unsigned CNT_W  = FIELD_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             step,
    output logic             last_byte,
    output logic             last_blk,
    output logic [CNT_W-1:0] live_bytes,
    output logic [CNT_W-1:0] live_blocks
);

    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bytes_q;
    logic [CNT_W-1:0] blocks_q;
    logic [CNT_W-1:0] field_p1;

    // Programmed value: the low field plus one.
    assign field_p1 = {1'b0, wr_data[FIELD_W-1:0]} + CNT_W'(1);

    assign last_byte   = (bytes_q == CNT_W'(1));
    assign last_blk    = (blocks_q == CNT_W'(1));
    assign live_bytes  = bytes_q;
    assign live_blocks = blocks_q;

    // Register writes, then per-byte counting with automatic reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q    <= '0;
            cnt_q    <= '0;
            bytes_q  <= '0;
            blocks_q <= '0;
        end else if (wr_en && !wr_sel) begin
            len_q   <= field_p1;
            bytes_q <= field_p1;
        end else if (wr_en && wr_sel) begin
            cnt_q    <= field_p1;
            blocks_q <= field_p1;
            bytes_q  <= len_q;
        end else if (step) begin
            if (last_byte) begin
                bytes_q <= len_q;
                if (last_blk) begin
                    blocks_q <= cnt_q;
                end else begin
                    blocks_q <= blocks_q - CNT_W'(1);
                end
            end else begin
                bytes_q <= bytes_q - CNT_W'(1);
            end
        end
    end

    assert_block_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !wr_en && last_byte && !last_blk)
        |=> (blocks_q == $past(blocks_q) - CNT_W'(1)));

    assert_count_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (bytes_q == len_q));

endmodule

// File: rtl/xfer_rx_packer.sv
// Module: accepts card bytes and packs them into 16-bit FIFO entries, low half
// first. A block's last byte in a low half is pushed alone with a zero high half.
// Assumes the FIFO fill level reflects a push from the next cycle on.
module xfer_rx_packer #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LVL_W  = 5,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              restart,
    input  logic [LVL_W:0]    fifo_level,
    input  logic [LVL_W-1:0]  af_level,
    input  logic              last_byte,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              step,
    output logic              push,
    output logic [WORD_W-1:0] push_data
);

    logic              half_q;
    logic [BYTE_W-1:0] lo_q;
    logic              room;
    logic              fire;

    // Room for a new entry only while the fill level is at or below the threshold.
    assign room      = (fifo_level <= {1'b0, af_level});
    assign rx_ready  = enable && (half_q || room);
    assign fire      = rx_valid && rx_ready;
    assign step      = fire;
    assign push      = fire && (half_q || last_byte);
    assign push_data = half_q ? {rx_data, lo_q} : {{BYTE_W{1'b0}}, rx_data};

    // Track whether a low byte is waiting for its high partner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
            lo_q   <= '0;
        end else if (restart) begin
            half_q <= 1'b0;
        end else if (fire) begin
            if (half_q || last_byte) begin
                half_q <= 1'b0;
            end else begin
                half_q <= 1'b1;
                lo_q   <= rx_data;
            end
        end
    end

    assert_pair_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && half_q && !restart) |=> !half_q);

    assert_rx_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !half_q) |-> (fifo_level <= {1'b0, af_level}));

endmodule

// File: rtl/xfer_tx_unpacker.sv
// Module: sends the FIFO head entry to the card as two bytes, low half first,
// and pops the entry after its second byte, or after the low byte when that
// byte ends a block. Assumes fifo_head is valid whenever fifo_level is nonzero.
module xfer_tx_unpacker #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned LVL_W  = 5,
    localparam int unsigned WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              restart,
    input  logic [LVL_W:0]    fifo_level,
    input  logic [WORD_W-1:0] fifo_head,
    input  logic              last_byte,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              step,
    output logic              pop
);

    logic half_q;
    logic fire;

    assign tx_valid = enable && (fifo_level != '0);
    assign tx_data  = half_q ? fifo_head[WORD_W-1:BYTE_W] : fifo_head[BYTE_W-1:0];
    assign fire     = tx_valid && tx_ready;
    assign step     = fire;
    assign pop      = fire && (half_q || last_byte);

    // Select which half of the head entry goes out next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (restart) begin
            half_q <= 1'b0;
        end else if (fire) begin
            half_q <= !(half_q || last_byte);
        end
    end

    assert_pop_nonempty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fifo_level != '0));

endmodule

// File: rtl/xfer_seq.sv
// Module: top of the block-counted transfer sequencer. Starts on a data
// transfer command, routes byte steps from the active direction into the
// counters and ends the transfer with a one-cycle done pulse.
// Assumes the external FIFO holds up to 2**LVL_W entries.
module xfer_seq
    import xfer_seq_pkg::*;
#(
    parameter int unsigned FIELD_W = 11,
    parameter int unsigned REG_W   = 16,
    parameter int unsigned LVL_W   = 5,
    localparam int unsigned CNT_W  = FIELD_W + 1,
    localparam int unsigned WORD_W = 2 * BYTE_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr_en,
    input  logic                 reg_wr_sel,
    input  logic [REG_W-1:0]     reg_wr_data,
    input  logic                 cmd_valid,
    input  logic [1:0]           cmd_type,
    input  logic                 cmd_dir,
    input  logic [LVL_W-1:0]     af_level,
    input  logic [LVL_W:0]       fifo_level,
    input  logic [WORD_W-1:0]    fifo_head,
    output logic                 fifo_flush,
    output logic                 fifo_push,
    output logic [WORD_W-1:0]    fifo_push_data,
    output logic                 fifo_pop,
    input  logic                 rx_valid,
    input  logic [BYTE_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 tx_valid,
    output logic [BYTE_BITS-1:0] tx_data,
    input  logic                 tx_ready,
    output logic                 xfer_active,
    output logic                 xfer_dir,
    output logic                 xfer_done,
    output logic [CNT_W-1:0]     live_bytes,
    output logic [CNT_W-1:0]     live_blocks
);

    logic active_q;
    logic dir_q;
    logic done_q;
    logic start;
    logic rx_step;
    logic tx_step;
    logic step;
    logic last_byte;
    logic last_blk;
    logic xfer_end;

    assign start      = cmd_valid && (cmd_kind_e'(cmd_type) == CMD_KIND_DATA);
    assign fifo_flush = start;
    assign step       = rx_step || tx_step;
    assign xfer_end   = step && last_byte && last_blk;

    assign xfer_active = active_q;
    assign xfer_dir    = dir_q;
    assign xfer_done   = done_q;

    // Transfer control: start or stop on commands, end on the final byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            dir_q    <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cmd_valid) begin
                active_q <= start;
                if (start) begin
                    dir_q <= cmd_dir;
                end
            end else if (xfer_end) begin
                active_q <= 1'b0;
                done_q   <= 1'b1;
            end
        end
    end

    xfer_blk_counters #(
        .FIELD_W (FIELD_W),
        .REG_W   (REG_W)
    ) counters_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_data     (reg_wr_data),
        .step        (step),
        .last_byte   (last_byte),
        .last_blk    (last_blk),
        .live_bytes  (live_bytes),
        .live_blocks (live_blocks)
    );

    xfer_rx_packer #(
        .BYTE_W (BYTE_BITS),
        .LVL_W  (LVL_W)
    ) rx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (active_q && dir_q),
        .restart    (start),
        .fifo_level (fifo_level),
        .af_level   (af_level),
        .last_byte  (last_byte),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_ready   (rx_ready),
        .step       (rx_step),
        .push       (fifo_push),
        .push_data  (fifo_push_data)
    );

    xfer_tx_unpacker #(
        .BYTE_W (BYTE_BITS),
        .LVL_W  (LVL_W)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (active_q && !dir_q),
        .restart    (start),
        .fifo_level (fifo_level),
        .fifo_head  (fifo_head),
        .last_byte  (last_byte),
        .tx_valid   (tx_valid),
        .tx_data    (tx_data),
        .tx_ready   (tx_ready),
        .step       (tx_step),
        .pop        (fifo_pop)
    );

    assert_one_direction_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));

    assert_done_ends_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> !xfer_active);

endmodule

// File: tb/xfer_seq_tb_top.sv
// Bench: scoreboard-driven test of the transfer sequencer with a FIFO model.
module xfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_wr_sel = 1'b0;
    logic [15:0] reg_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_type = '0;
    logic        cmd_dir = 1'b0;
    logic [4:0]  af_level = 5'd31;
    logic [5:0]  fifo_level = '0;
    logic [15:0] fifo_head = '0;
    logic        fifo_flush, fifo_push, fifo_pop;
    logic [15:0] fifo_push_data;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        xfer_active, xfer_dir, xfer_done;
    logic [11:0] live_bytes, live_blocks;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int tx_seen = 0;
    logic [15:0] exp_push[$];
    logic [7:0]  exp_tx[$];
    logic [15:0] fq[$];
    logic        load_en = 1'b0;
    logic [15:0] load_word = '0;
    logic        drain_req = 1'b0;

    always #10 clk = ~clk;

    xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
        .reg_wr_data(reg_wr_data), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_dir(cmd_dir), .af_level(af_level), .fifo_level(fifo_level),
        .fifo_head(fifo_head), .fifo_flush(fifo_flush), .fifo_push(fifo_push),
        .fifo_push_data(fifo_push_data), .fifo_pop(fifo_pop), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .xfer_done(xfer_done), .live_bytes(live_bytes), .live_blocks(live_blocks)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // FIFO model: flush, pop, push, bench loads and drains.
    always @(posedge clk) begin
        if (fifo_flush || drain_req) begin
            fq.delete();
        end else begin
            if (fifo_pop && fq.size() != 0) void'(fq.pop_front());
            if (fifo_push) fq.push_back(fifo_push_data);
        end
        if (load_en) fq.push_back(load_word);
        fifo_level <= 6'(fq.size());
        fifo_head  <= (fq.size() != 0) ? fq[0] : 16'h0;
    end

    // Monitor: compare pushed entries and sent bytes with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (fifo_push) begin
                if (exp_push.size() == 0) chk("R5 unexpected push", {16'h0, fifo_push_data}, 32'hFFFF_FFFF);
                else chk("R5/R6 pushed entry", {16'h0, fifo_push_data}, {16'h0, exp_push.pop_front()});
            end
            if (tx_valid && tx_ready) begin
                tx_seen++;
                if (exp_tx.size() == 0) chk("R8 unexpected byte", {24'h0, tx_data}, 32'hFFFF_FFFF);
                else chk("R8 sent byte", {24'h0, tx_data}, {24'h0, exp_tx.pop_front()});
            end
            if (xfer_done) done_seen++;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    task automatic wr_reg(input logic sel, input logic [15:0] d);
        @(posedge clk); #1 reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = d;
        @(posedge clk); #1 reg_wr_en = 1'b0;
    endtask

    task automatic issue_cmd(input logic [1:0] t, input logic d, input logic exp_flush);
        @(posedge clk); #1 cmd_valid = 1'b1; cmd_type = t; cmd_dir = d;
        @(negedge clk); chk("R4 flush on command", {31'h0, fifo_flush}, {31'h0, exp_flush});
        @(posedge clk); #1 cmd_valid = 1'b0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        do @(negedge clk); while (!rx_ready);
        @(posedge clk); #1 rx_valid = 1'b0;
    endtask

    task automatic load(input logic [15:0] w);
        @(posedge clk); #1 load_en = 1'b1; load_word = w;
        @(posedge clk); #1 load_en = 1'b0;
    endtask

    // Expected entries for a receive transfer of nb blocks of len bytes from base.
    task automatic expect_rx(input int len, input int nb, input logic [7:0] base);
        logic [7:0] b = base;
        for (int k = 0; k < nb; k++) begin
            for (int i = 0; i < len; i += 2) begin
                if (i + 1 < len) begin
                    exp_push.push_back({b + 8'd1, b});
                    b = b + 8'd2;
                end else begin
                    exp_push.push_back({8'h00, b});
                    b = b + 8'd1;
                end
            end
        end
    endtask

    initial begin
        int d0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset active", {31'h0, xfer_active}, 32'h0);
        chk("R1 reset live bytes", {20'h0, live_bytes}, 32'h0);
        chk("R1 reset live blocks", {20'h0, live_blocks}, 32'h0);
        chk("R1 reset handshakes", {30'h0, rx_ready, tx_valid}, 32'h0);
        @(posedge clk); #1 rst_n = 1'b1;

        // R2: field plus one, upper bits ignored; maximum field gives 2048.
        wr_reg(1'b0, 16'hF805);
        chk("R2 length 0xF805", {20'h0, live_bytes}, 32'd6);
        wr_reg(1'b0, 16'h07FF);
        chk("R2 length max", {20'h0, live_bytes}, 32'd2048);
        wr_reg(1'b1, 16'h0001);
        chk("R3 count live", {20'h0, live_blocks}, 32'd2);
        chk("R3 count reloads bytes", {20'h0, live_bytes}, 32'd2048);

        // Receive: 2 blocks of 5 bytes.
        wr_reg(1'b0, 16'd4);
        wr_reg(1'b1, 16'd1);
        af_level = 5'd31;
        expect_rx(5, 2, 8'h10);
        d0 = done_seen;
        issue_cmd(2'd3, 1'b1, 1'b1);
        chk("R4 active after start", {31'h0, xfer_active}, 32'h1);
        chk("R4 dir latched", {31'h0, xfer_dir}, 32'h1);
        for (int i = 0; i < 5; i++) send_rx(8'h10 + 8'(i));
        chk("R10 blocks after block", {20'h0, live_blocks}, 32'd1);
        chk("R10 bytes reloaded", {20'h0, live_bytes}, 32'd5);
        for (int i = 5; i < 10; i++) send_rx(8'h10 + 8'(i));
        repeat (2) @(negedge clk);
        chk("R11 one done pulse", done_seen - d0, 32'd1);
        chk("R11 inactive", {31'h0, xfer_active}, 32'h0);
        chk("R11 blocks reload", {20'h0, live_blocks}, 32'd2);
        chk("R6 all entries seen", exp_push.size(), 32'd0);
        rx_valid = 1'b1; rx_data = 8'hEE;
        @(negedge clk);
        chk("R12 idle no ready", {31'h0, rx_ready}, 32'h0);
        @(posedge clk); #1 rx_valid = 1'b0;

        // R7: pause on the threshold, 1 block of 8 bytes, af_level 1.
        wr_reg(1'b0, 16'd7);
        wr_reg(1'b1, 16'd0);
        af_level = 5'd1;
        expect_rx(8, 1, 8'h20);
        issue_cmd(2'd3, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) send_rx(8'h20 + 8'(i));
        rx_valid = 1'b1; rx_data = 8'h24;
        repeat (2) @(negedge clk);
        chk("R7 level", {26'h0, fifo_level}, 32'd2);
        chk("R7 stalled", {31'h0, rx_ready}, 32'h0);
        chk("R7 bytes held", {20'h0, live_bytes}, 32'd4);
        @(posedge clk); #1 drain_req = 1'b1;
        @(posedge clk); #1 drain_req = 1'b0;
        for (int i = 4; i < 8; i++) send_rx(8'h20 + 8'(i));
        repeat (2) @(negedge clk);
        chk("R7 done after resume", {31'h0, xfer_active}, 32'h0);
        chk("R7 entries seen", exp_push.size(), 32'd0);

        // R4: a non-transfer command stops without flushing.
        af_level = 5'd31;
        issue_cmd(2'd3, 1'b1, 1'b1);
        exp_push.push_back(16'h0000);
        void'(exp_push.pop_back());
        send_rx(8'h30);
        issue_cmd(2'd2, 1'b0, 1'b0);
        chk("R4 stopped by other command", {31'h0, xfer_active}, 32'h0);
        chk("R4 bytes frozen", {20'h0, live_bytes}, 32'd7);
        chk("R4 fifo kept", {26'h0, fifo_level}, 32'd0);

        // Transmit: 2 blocks of 5 bytes, with an empty FIFO in between.
        wr_reg(1'b0, 16'd4);
        wr_reg(1'b1, 16'd1);
        d0 = done_seen;
        tx_seen = 0;
        tx_ready = 1'b0;
        issue_cmd(2'd3, 1'b0, 1'b1);
        load(16'hB1A1); load(16'hB2A2); load(16'hB3A3);
        @(negedge clk);
        chk("R12 backpressure holds", {20'h0, live_bytes}, 32'd5);
        chk("R8 preload level", {26'h0, fifo_level}, 32'd3);
        exp_tx = '{8'hA1, 8'hB1, 8'hA2, 8'hB2, 8'hA3};
        tx_ready = 1'b1;
        while (tx_seen < 5) @(posedge clk);
        @(negedge clk);
        chk("R9 empty no valid", {31'h0, tx_valid}, 32'h0);
        chk("R8 short block popped", {26'h0, fifo_level}, 32'd0);
        chk("R10 tx blocks", {20'h0, live_blocks}, 32'd1);
        exp_tx.push_back(8'hC4); exp_tx.push_back(8'hD4);
        exp_tx.push_back(8'hC5); exp_tx.push_back(8'hD5);
        exp_tx.push_back(8'hC6);
        load(16'hD4C4); load(16'hD5C5); load(16'hD6C6);
        while (tx_seen < 10) @(posedge clk);
        repeat (2) @(negedge clk);
        chk("R11 tx done pulse", done_seen - d0, 32'd1);
        chk("R11 tx inactive", {31'h0, xfer_active}, 32'h0);
        chk("R8 all bytes seen", exp_tx.size(), 32'd0);
        chk("R8 fifo emptied", {26'h0, fifo_level}, 32'd0);
        tx_ready = 1'b0;

        // R6: length one, every byte its own half-used entry.
        wr_reg(1'b0, 16'd0);
        wr_reg(1'b1, 16'd2);
        expect_rx(1, 3, 8'h40);
        issue_cmd(2'd3, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) send_rx(8'h40 + 8'(i));
        repeat (2) @(negedge clk);
        chk("R6 single-byte entries", exp_push.size(), 32'd0);
        chk("R11 len1 inactive", {31'h0, xfer_active}, 32'h0);
        chk("R11 len1 blocks reload", {20'h0, live_blocks}, 32'd3);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule